// File: doc/BRIEF.md
# USB Endpoint CPU Buffer Controller

This block holds the CPU-side control and status state of one USB endpoint buffer. It keeps an offset register that addresses the endpoint's packet memory for CPU data accesses. When auto-increment is on, each CPU access advances the offset, and the offset wraps at the configured buffer depth. The block also holds the endpoint direction, a full flag for the buffer the CPU owns, a full flag for the buffer the USB side owns, a status-phase enable used only on the control endpoint, and a packet length register.

Software drives a plain command write port. Each write carries single-cycle command bits: clear endpoint, buffer done, set read direction, set write direction and status-phase enable. These bits are not stored anywhere, so reading them back would always give zero and they clear themselves. Every command takes effect at the clock edge on which it is written, and every output updates one cycle later.

The interaction between commands is the core of the block:
- Clear overrides every other command written in the same access, and it also overrides a data access strobe in the same cycle.
- Clear keeps the status-phase enable only when that enable is written in the same access.
- A done command on an endpoint that the USB side reads, with auto-increment on, captures the offset as the packet length.

All pins are plain level or strobe signals, with no handshake. The CPU access strobe and the USB-side completion strobe are single-cycle events that are always accepted, so there is no back-pressure.

Top module: `usb_ep_cpu_buf_ctrl`

## Requirements
- R1: A write with `cmd_clear` set makes `ofs` read 0 on the next cycle, even if `acc_stb` is high in the same cycle.
- R2: A clear write makes `cpu_buf_full` and `usb_buf_full` read 0 on the next cycle. It also overrides `cmd_done` and `usb_done` in the same cycle.
- R3: A clear write leaves `dir_cpu2usb` unchanged, and any `cmd_set_rd` or `cmd_set_wr` in the same write is ignored.
- R4: `cmd_set_rd` sets `dir_cpu2usb` to 1 (the CPU fills and the USB side reads). `cmd_set_wr` sets it to 0 (the USB side fills and the CPU reads). If both are written together, `cmd_set_rd` wins.
- R5: `cmd_done` sets `cpu_buf_full` to 1 when `dir_cpu2usb`=1 and to 0 when it is 0. `usb_done` sets `usb_buf_full` to 0 when `dir_cpu2usb`=1 and to 1 when it is 0. In each case the direction used is the value held before the edge.
- R6: `cmd_stat_en` sets `stat_en`. On a control endpoint (`IS_CTRL_EP`=1), a clear written without `cmd_stat_en` resets `stat_en`, while a clear written with it keeps `stat_en` at 1. On any other endpoint, `stat_en` stays 0.
- R7: A done write with `dir_cpu2usb`=1 and `inc_en`=1 loads `ep_len` with the offset held before that edge. A done write with `inc_en`=0 or `dir_cpu2usb`=0 leaves `ep_len` unchanged.
- R8: With `inc_en`=1, each `acc_stb` raises `ofs` by one, and `ofs` wraps from BUF_DEPTH-1 to 0. With `inc_en`=0, `acc_stb` leaves `ofs` unchanged.
- R9: After a synchronous low `rst_n`, `ofs`, `ep_len`, `cpu_buf_full`, `usb_buf_full` and `stat_en` are 0, and `dir_cpu2usb` is 1.
- R10: When `cmd_valid` is 0, all command bits are ignored. A command acts once, only on the cycle in which it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_clear | input | 1 | Clear endpoint command bit |
| cmd_done | input | 1 | CPU buffer done command bit |
| cmd_set_rd | input | 1 | Set direction to CPU-to-USB |
| cmd_set_wr | input | 1 | Set direction to USB-to-CPU |
| cmd_stat_en | input | 1 | Status-phase enable command bit |
| inc_en | input | 1 | Auto-increment enable (configuration level) |
| acc_stb | input | 1 | One CPU data access to packet memory |
| usb_done | input | 1 | The USB side has finished its buffer |
| ofs | output | OFS_W | CPU address offset into the packet memory |
| dir_cpu2usb | output | 1 | 1 when data flows from the CPU to USB |
| cpu_buf_full | output | 1 | The CPU-owned buffer is full |
| usb_buf_full | output | 1 | The USB-owned buffer is full |
| stat_en | output | 1 | Status phase enabled |
| ep_len | output | OFS_W | Endpoint packet length |

## Verification
A wrong offset appears directly on `ofs` in the cycle after the access or clear that caused it. It also reappears later as a wrong `ep_len` after the next done command with auto-increment on. A wrong direction bit shows on `dir_cpu2usb` at once. It then flips the polarity of the next done or USB completion event on the two full flags, so the fault stays visible for one cycle after that event. A status-phase enable that the clear wrongly kept or lost is visible on `stat_en` in the cycle after the clear.

// File: rtl/usb_epbuf_pkg.sv
package usb_epbuf_pkg;
  localparam logic DIR_CPU2USB = 1'b1;
  localparam logic DIR_USB2CPU = 1'b0;

  typedef struct packed {
    logic clr;
    logic done;
    logic set_rd;
    logic set_wr;
    logic stat;
  } epbuf_cmd_t;
endpackage

// File: rtl/epbuf_offset_ctr.sv
module epbuf_offset_ctr #(
  parameter int DEPTH = 12,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] ofs
);
  localparam logic [W-1:0] LAST = W'(DEPTH - 1);

  logic [W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        ofs_q <= '0;
    else if (clr)      ofs_q <= '0;
    else if (adv)      ofs_q <= (ofs_q == LAST) ? '0 : ofs_q + 1'b1;
  end

  assign ofs = ofs_q;

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ofs == '0));
  assert_advance_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (ofs == (($past(ofs) == LAST) ? '0 : $past(ofs) + 1'b1)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ofs));
endmodule

// File: rtl/epbuf_flags.sv
module epbuf_flags #(
  parameter bit CTRL_EP = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic done,
  input  logic set_rd,
  input  logic set_wr,
  input  logic stat_set,
  input  logic usb_done,
  output logic dir,
  output logic cbf,
  output logic ubf,
  output logic stat_en
);
  import usb_epbuf_pkg::*;

  logic dir_q, cbf_q, ubf_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       dir_q <= DIR_CPU2USB;
    else if (set_rd)  dir_q <= DIR_CPU2USB;
    else if (set_wr)  dir_q <= DIR_USB2CPU;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cbf_q <= 1'b0;
      ubf_q <= 1'b0;
    end else if (clr) begin
      cbf_q <= 1'b0;
      ubf_q <= 1'b0;
    end else begin
      if (done)     cbf_q <= (dir_q == DIR_CPU2USB);
      if (usb_done) ubf_q <= (dir_q == DIR_USB2CPU);
    end
  end

  generate
    if (CTRL_EP) begin : g_ctrl
      logic stat_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= 1'b0;
        else if (stat_set) stat_q <= 1'b1;
        else if (clr)      stat_q <= 1'b0;
      end
      assign stat_en = stat_q;

      assert_stat_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !stat_set) |=> !stat_en);
    end else begin : g_plain
      assign stat_en = 1'b0;
    end
  endgenerate

  assign dir = dir_q;
  assign cbf = cbf_q;
  assign ubf = ubf_q;

  assert_clear_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!cbf && !ubf));
  assert_clear_keeps_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> $stable(dir));
  assert_done_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (cbf == $past(dir)));
endmodule

// File: rtl/epbuf_len_reg.sv
module epbuf_len_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic         dir,
  input  logic         inc_en,
  input  logic [W-1:0] ofs,
  output logic [W-1:0] len
);
  import usb_epbuf_pkg::*;

  logic [W-1:0] len_q;
  logic         load;

  assign load = done && inc_en && (dir == DIR_CPU2USB);

  always_ff @(posedge clk) begin
    if (!rst_n)    len_q <= '0;
    else if (load) len_q <= ofs;
  end

  assign len = len_q;

  assert_len_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && inc_en && dir) |=> (len == $past(ofs)));
  assert_len_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en || !dir) |=> $stable(len));
endmodule

// File: rtl/usb_ep_cpu_buf_ctrl.sv
module usb_ep_cpu_buf_ctrl #(
  parameter int BUF_DEPTH  = 12,
  parameter bit IS_CTRL_EP = 1'b1,
  localparam int OFS_W     = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_clear,
  input  logic             cmd_done,
  input  logic             cmd_set_rd,
  input  logic             cmd_set_wr,
  input  logic             cmd_stat_en,
  input  logic             inc_en,
  input  logic             acc_stb,
  input  logic             usb_done,
  output logic [OFS_W-1:0] ofs,
  output logic             dir_cpu2usb,
  output logic             cpu_buf_full,
  output logic             usb_buf_full,
  output logic             stat_en,
  output logic [OFS_W-1:0] ep_len
);
  import usb_epbuf_pkg::*;

  epbuf_cmd_t cmd;
  logic       usb_done_eff;

  always_comb begin
    cmd.clr    = cmd_valid && cmd_clear;
    cmd.done   = cmd_valid && cmd_done && !cmd_clear;
    cmd.set_rd = cmd_valid && cmd_set_rd && !cmd_clear;
    cmd.set_wr = cmd_valid && cmd_set_wr && !cmd_set_rd && !cmd_clear;
    cmd.stat   = cmd_valid && cmd_stat_en;
  end

  assign usb_done_eff = usb_done && !cmd.clr;

  epbuf_offset_ctr #(.DEPTH(BUF_DEPTH), .W(OFS_W)) u_ofs (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd.clr),
    .adv   (acc_stb && inc_en),
    .ofs   (ofs)
  );

  epbuf_flags #(.CTRL_EP(IS_CTRL_EP)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd.clr),
    .done     (cmd.done),
    .set_rd   (cmd.set_rd),
    .set_wr   (cmd.set_wr),
    .stat_set (cmd.stat),
    .usb_done (usb_done_eff),
    .dir      (dir_cpu2usb),
    .cbf      (cpu_buf_full),
    .ubf      (usb_buf_full),
    .stat_en  (stat_en)
  );

  epbuf_len_reg #(.W(OFS_W)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (cmd.done),
    .dir    (dir_cpu2usb),
    .inc_en (inc_en),
    .ofs    (ofs),
    .len    (ep_len)
  );

  assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !acc_stb && !usb_done) |=>
      ($stable(ofs) && $stable(dir_cpu2usb) && $stable(cpu_buf_full) &&
       $stable(usb_buf_full) && $stable(stat_en) && $stable(ep_len)));
  assert_clear_blocks_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_clear) |=> $stable(dir_cpu2usb));
endmodule

// File: tb/usb_ep_cpu_buf_ctrl_bench.sv
module usb_ep_cpu_buf_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_clear = 0, cmd_done = 0, cmd_set_rd = 0, cmd_set_wr = 0;
  logic cmd_stat_en = 0, inc_en = 0, acc_stb = 0, usb_done = 0;
  logic [3:0] ofs, ep_len, ofs_n, ep_len_n;
  logic dir, cbf, ubf, stat, dir_n, cbf_n, ubf_n, stat_n;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  usb_ep_cpu_buf_ctrl #(.BUF_DEPTH(12), .IS_CTRL_EP(1'b1)) u_usb_ep_cpu_buf_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_clear(cmd_clear),
    .cmd_done(cmd_done), .cmd_set_rd(cmd_set_rd), .cmd_set_wr(cmd_set_wr),
    .cmd_stat_en(cmd_stat_en), .inc_en(inc_en), .acc_stb(acc_stb), .usb_done(usb_done),
    .ofs(ofs), .dir_cpu2usb(dir), .cpu_buf_full(cbf), .usb_buf_full(ubf),
    .stat_en(stat), .ep_len(ep_len));

  usb_ep_cpu_buf_ctrl #(.BUF_DEPTH(12), .IS_CTRL_EP(1'b0)) u_usb_ep_cpu_buf_ctrl_nc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_clear(cmd_clear),
    .cmd_done(cmd_done), .cmd_set_rd(cmd_set_rd), .cmd_set_wr(cmd_set_wr),
    .cmd_stat_en(cmd_stat_en), .inc_en(inc_en), .acc_stb(acc_stb), .usb_done(usb_done),
    .ofs(ofs_n), .dir_cpu2usb(dir_n), .cpu_buf_full(cbf_n), .usb_buf_full(ubf_n),
    .stat_en(stat_n), .ep_len(ep_len_n));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cmd_valid = 0; cmd_clear = 0; cmd_done = 0; cmd_set_rd = 0; cmd_set_wr = 0;
    cmd_stat_en = 0; acc_stb = 0; usb_done = 0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin acc_stb = 1; step(); end
  endtask

  task automatic wr(input logic c, input logic d, input logic r, input logic w, input logic s);
    cmd_valid = 1; cmd_clear = c; cmd_done = d; cmd_set_rd = r; cmd_set_wr = w; cmd_stat_en = s;
  endtask

  task automatic t_reset();
    check("R9 ofs", ofs, 0); check("R9 len", ep_len, 0); check("R9 dir", dir, 1);
    check("R9 cbf", cbf, 0); check("R9 ubf", ubf, 0); check("R9 stat", stat, 0);
  endtask

  task automatic t_incr();
    inc_en = 1;
    strobes(11); check("R8 count", ofs, 11);
    strobes(1);  check("R8 wrap", ofs, 0);
    strobes(3);  check("R8 after wrap", ofs, 3);
    inc_en = 0;
    strobes(2);  check("R8 inc off", ofs, 3);
  endtask

  task automatic t_clear();
    inc_en = 1; strobes(2);
    check("R1 pre", ofs, 5);
    wr(1, 0, 0, 0, 0); acc_stb = 1; step();
    check("R1 clear beats strobe", ofs, 0);
  endtask

  task automatic t_dir();
    wr(0, 0, 0, 1, 0); step(); check("R4 set_wr", dir, 0);
    wr(0, 0, 1, 0, 0); step(); check("R4 set_rd", dir, 1);
    wr(0, 0, 0, 1, 0); step();
    wr(0, 0, 1, 1, 0); step(); check("R4 both rd wins", dir, 1);
    wr(1, 0, 0, 1, 0); step(); check("R3 clear blocks set_wr", dir, 1);
    wr(0, 0, 0, 1, 0); step();
    wr(1, 0, 1, 0, 0); step(); check("R3 clear blocks set_rd", dir, 0);
  endtask

  task automatic t_flags();
    usb_done = 1; step(); check("R5 usb_done dir0", ubf, 1);
    wr(0, 1, 0, 0, 0); step(); check("R5 done dir0", cbf, 0);
    wr(0, 0, 1, 0, 0); step();
    wr(0, 1, 0, 0, 0); step(); check("R5 done dir1", cbf, 1);
    usb_done = 1; step(); check("R5 usb_done dir1", ubf, 0);
    wr(0, 0, 0, 1, 0); step();
    usb_done = 1; step(); check("R5 ubf set", ubf, 1);
    wr(0, 0, 1, 0, 0); step();
    wr(0, 1, 0, 0, 0); step(); check("R5 cbf set", cbf, 1);
    wr(1, 0, 0, 0, 0); step();
    check("R2 clear cbf", cbf, 0); check("R2 clear ubf", ubf, 0);
    wr(1, 1, 0, 0, 0); usb_done = 0; step(); check("R2 clear beats done", cbf, 0);
  endtask

  task automatic t_len();
    inc_en = 1; wr(1, 0, 1, 0, 0); step();
    strobes(7);
    wr(0, 1, 0, 0, 0); step(); check("R7 capture", ep_len, 7);
    strobes(2);
    wr(0, 1, 0, 0, 0); acc_stb = 1; step();
    check("R7 pre-increment value", ep_len, 9); check("R8 with done", ofs, 10);
    inc_en = 0; wr(0, 1, 0, 0, 0); step(); check("R7 inc off holds", ep_len, 9);
    inc_en = 1; wr(0, 0, 0, 1, 0); step();
    wr(0, 1, 0, 0, 0); step(); check("R7 dir0 holds", ep_len, 9);
  endtask

  task automatic t_stat();
    wr(0, 0, 0, 0, 1); step(); check("R6 set", stat, 1);
    check("R6 non-ctrl zero", stat_n, 0);
    wr(1, 0, 0, 0, 1); step(); check("R6 clear with enable keeps", stat, 1);
    wr(1, 0, 0, 0, 0); step(); check("R6 clear alone drops", stat, 0);
  endtask

  task automatic t_valid();
    inc_en = 1; strobes(4);
    wr(0, 0, 1, 0, 0); step();
    wr(0, 1, 0, 0, 1); step();
    cmd_clear = 1; cmd_set_wr = 1; cmd_done = 1; cmd_stat_en = 1; step();
    check("R10 no clear", ofs, 4); check("R10 no dir", dir, 1);
    check("R10 cbf kept", cbf, 1); check("R10 stat kept", stat, 1);
    step(); check("R10 one-shot", ofs, 4);
  endtask

  initial begin
    fork
      begin
        step(); step(); rst_n = 1; #0;
        t_reset(); t_incr(); t_clear(); t_dir(); t_flags(); t_len(); t_stat(); t_valid();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule